// File: doc/BRIEF.md
# Multi-Lane Serial Flash Transaction Sequencer

This block carries out one serial flash transaction from start to finish. A caller presents a descriptor and pulses `start`. The descriptor gives an opcode, an address byte count and value, a dummy byte count, a data direction and length, and separate lane widths for the address and data phases. The block then frames the transfer with an active-low chip select and produces a serial clock at half the system clock rate.

It sends the phases in a fixed order: opcode, address, dummy, data. Each byte is shifted most significant bit first. It drives between one and four IO lanes and enables each lane's output driver only while that lane carries outgoing bits. Bytes for a write are taken from `wr_data`, and `wr_take` acknowledges each one. Bytes from a read come out on `rd_data` together with a one-cycle `rd_valid` strobe. A one-cycle `done` pulse marks the end of the transaction.

Which flash operation to issue is decided outside the block. The sequencer only serialises the descriptor it is given.

Top module: `sflash_seq`

## Requirements
- R1: After reset and while idle, `cs_n` is 1, `sclk` is 0, `io_oe` is 0, and `busy`, `done`, `rd_valid` and `wr_take` are 0.
- R2: `cs_n` goes low on the clock edge that accepts `start`, which is one clock before the first rising edge of `sclk`. It returns high one clock after the last falling edge of `sclk`. `done` is 1 for exactly that one cycle, and `busy` is 1 from the accepting edge up to that cycle.
- R3: `sclk` runs at half the clock rate. Each bit slot, called a beat, spends one cycle low and then one cycle high. `sclk` toggles only while `cs_n` is low.
- R4: The opcode byte always goes first. It is sent over 8 beats on lane 0 only (`io_oe` = 4'b0001), most significant bit first.
- R5: `addr_count` (0 to 3) address bytes follow the opcode. They come from the low bytes of `addr_value`, most significant byte first, and are driven on the lane width given by `addr_lanes`.
- R6: `dummy_count` dummy bytes follow the address bytes. They use the address lane width, and during them all output drivers are off (`io_oe` = 0).
- R7: Lane codes are 0 for 1 lane, 1 for 2 lanes, and 2 or 3 for 4 lanes, giving 8, 4 or 2 beats per byte. On 1 lane the bit goes out on IO0. On 2 lanes the higher bit of each pair goes on IO1. On 4 lanes the nibble goes on IO3..IO0 with the high bit on IO3. `io_oe` enables exactly the lanes in use while the block is driving.
- R8: When `data_dir` is 2 (write), `data_count` bytes follow the dummy bytes on `data_lanes`. Each byte is captured from `wr_data` as its first beat starts, and `wr_take` is 1 for that one cycle.
- R9: When `data_dir` is 1 (read), `data_count` bytes are received with all drivers off. Input is sampled on the rising edge of `sclk`: from IO1 on 1 lane, from {IO1,IO0} on 2 lanes, and from IO3..IO0 on 4 lanes. Each byte appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after the falling edge that ends its last beat.
- R10: A `start` that arrives while `busy` is 1 is ignored. It has no effect on the transaction in progress.
- R11: With zero address bytes, zero dummy bytes, and either `data_dir` = 0 or `data_count` = 0, only the opcode is sent before the transaction finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| op_code | input | 8 | Opcode byte |
| addr_count | input | 2 | Number of address bytes, 0 to 3 |
| addr_value | input | 8*ADDR_BYTES_MAX | Address value, low bytes used |
| dummy_count | input | DUMMY_W | Number of dummy bytes |
| data_dir | input | 2 | 0 none, 1 read, 2 write |
| data_count | input | LEN_W | Number of data bytes |
| addr_lanes | input | 2 | Lane code for address and dummy |
| data_lanes | input | 2 | Lane code for data |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
Count cycles from the cycle that follows the edge accepting `start`, and call that cycle 0. For a transaction of N beats, beat b is presented in cycles 2b and 2b+1, with `sclk` high in the odd cycle. A received byte whose last beat is b shows `rd_valid` in cycle 2b+2. `wr_take` shows in cycle 2b when b is the first beat of a written byte. Cycle 2N is the trailing low cycle, and cycle 2N+1 shows `cs_n` high together with `done`. The bench builds a per-beat expectation list for each descriptor and compares every output at the falling edge of each of those cycles. It drives `io_in` at the falling edge before the rising edge on which the design samples it.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } sfs_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } sfs_state_e;

  localparam logic [1:0] DIR_NONE = 2'd0;
  localparam logic [1:0] DIR_IN   = 2'd1;
  localparam logic [1:0] DIR_OUT  = 2'd2;

  localparam logic [1:0] LANE_X1 = 2'd0;
  localparam logic [1:0] LANE_X2 = 2'd1;

  function automatic logic [3:0] beats_per_byte(input logic [1:0] code);
    case (code)
      LANE_X1: beats_per_byte = 4'd8;
      LANE_X2: beats_per_byte = 4'd4;
      default: beats_per_byte = 4'd2;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      LANE_X1: lane_mask = 4'b0001;
      LANE_X2: lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/sfs_phase_plan.sv
module sfs_phase_plan
  import sfs_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DUMMY_W = 3,
  parameter int LEN_W   = 8
) (
  input  sfs_phase_e         cur_phase,
  input  logic [CNT_W-1:0]   cur_cnt,
  input  logic [1:0]         addr_count,
  input  logic [DUMMY_W-1:0] dummy_count,
  input  logic [1:0]         data_dir,
  input  logic [LEN_W-1:0]   data_count,
  output logic               nxt_valid,
  output sfs_phase_e         nxt_phase,
  output logic [CNT_W-1:0]   nxt_cnt
);

  logic want_addr, want_dummy, want_data;

  always_comb begin
    want_addr  = (cur_phase == PH_CMD) && (addr_count != 2'd0);
    want_dummy = ((cur_phase == PH_CMD) || (cur_phase == PH_ADDR)) &&
                 (dummy_count != '0);
    want_data  = (cur_phase != PH_DATA) &&
                 ((data_dir == DIR_IN) || (data_dir == DIR_OUT)) &&
                 (data_count != '0);

    nxt_valid = 1'b1;
    nxt_phase = cur_phase;
    nxt_cnt   = '0;
    if (cur_cnt != '0) begin
      nxt_cnt = cur_cnt - CNT_W'(1);
    end else if (want_addr) begin
      nxt_phase = PH_ADDR;
      nxt_cnt   = CNT_W'(addr_count) - CNT_W'(1);
    end else if (want_dummy) begin
      nxt_phase = PH_DUMMY;
      nxt_cnt   = CNT_W'(dummy_count) - CNT_W'(1);
    end else if (want_data) begin
      nxt_phase = PH_DATA;
      nxt_cnt   = CNT_W'(data_count) - CNT_W'(1);
    end else begin
      nxt_valid = 1'b0;
    end
  end

endmodule

// File: rtl/sfs_lane_io.sv
module sfs_lane_io
  import sfs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       lane_code,
  input  logic [7:0]       sh,
  input  logic             sample_en,
  input  logic [LANES-1:0] io_in,
  output logic [LANES-1:0] io_out,
  output logic [7:0]       rd_byte
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int X2_BIT = 6 + (i % 2);
    localparam int X4_BIT = 4 + (i % 4);
    logic bit_o;
    always_comb begin
      case (lane_code)
        LANE_X1: bit_o = (i == 0) ? sh[7] : 1'b0;
        LANE_X2: bit_o = (i < 2) ? sh[X2_BIT] : 1'b0;
        default: bit_o = sh[X4_BIT];
      endcase
    end
    assign io_out[i] = bit_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
    end else if (sample_en) begin
      case (lane_code)
        LANE_X1: rd_byte <= {rd_byte[6:0], io_in[1]};
        LANE_X2: rd_byte <= {rd_byte[5:0], io_in[1:0]};
        default: rd_byte <= {rd_byte[3:0], io_in[3:0]};
      endcase
    end
  end

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfs_pkg::*;
#(
  parameter int ADDR_BYTES_MAX = 3,
  parameter int DUMMY_W        = 3,
  parameter int LEN_W          = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [7:0]                  op_code,
  input  logic [1:0]                  addr_count,
  input  logic [8*ADDR_BYTES_MAX-1:0] addr_value,
  input  logic [DUMMY_W-1:0]          dummy_count,
  input  logic [1:0]                  data_dir,
  input  logic [LEN_W-1:0]            data_count,
  input  logic [1:0]                  addr_lanes,
  input  logic [1:0]                  data_lanes,
  input  logic [7:0]                  wr_data,
  output logic                        wr_take,
  output logic [7:0]                  rd_data,
  output logic                        rd_valid,
  output logic                        busy,
  output logic                        done,
  output logic                        cs_n,
  output logic                        sclk,
  output logic [3:0]                  io_out,
  output logic [3:0]                  io_oe,
  input  logic [3:0]                  io_in
);

  localparam int ADDR_W = 8 * ADDR_BYTES_MAX;
  localparam int MAX_DL = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W;
  localparam int CNT_W  = (MAX_DL > 2) ? MAX_DL : 2;

  sfs_state_e         state;
  sfs_phase_e         phase;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         beats;
  logic [7:0]         sh;
  logic [1:0]         lane_r;
  logic [3:0]         oe_r;
  logic               cs_n_r, sclk_r, done_r, rd_valid_r, wr_take_r;
  logic [7:0]         rd_data_r;

  logic [1:0]         d_acnt;
  logic [ADDR_W-1:0]  d_addr;
  logic [DUMMY_W-1:0] d_dummy;
  logic [1:0]         d_dir;
  logic [LEN_W-1:0]   d_len;
  logic [1:0]         d_alane;
  logic [1:0]         d_dlane;

  logic               nxt_valid;
  sfs_phase_e         nxt_phase;
  logic [CNT_W-1:0]   nxt_cnt;
  logic [7:0]         nxt_byte;
  logic [1:0]         nxt_lane;
  logic               nxt_drive;
  logic [7:0]         sh_next;
  logic [7:0]         rd_byte;
  logic               sample_en;

  sfs_phase_plan #(
    .CNT_W  (CNT_W),
    .DUMMY_W(DUMMY_W),
    .LEN_W  (LEN_W)
  ) u_plan (
    .cur_phase  (phase),
    .cur_cnt    (cnt),
    .addr_count (d_acnt),
    .dummy_count(d_dummy),
    .data_dir   (d_dir),
    .data_count (d_len),
    .nxt_valid  (nxt_valid),
    .nxt_phase  (nxt_phase),
    .nxt_cnt    (nxt_cnt)
  );

  assign sample_en = (state == ST_LOW) && (phase == PH_DATA) && (d_dir == DIR_IN);

  sfs_lane_io #(
    .LANES(4)
  ) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .lane_code(lane_r),
    .sh       (sh),
    .sample_en(sample_en),
    .io_in    (io_in),
    .io_out   (io_out),
    .rd_byte  (rd_byte)
  );

  // Byte, lane width and drive choice for the byte that follows
  always_comb begin
    nxt_byte  = 8'h00;
    nxt_lane  = LANE_X1;
    nxt_drive = 1'b0;
    case (nxt_phase)
      PH_ADDR: begin
        nxt_byte  = d_addr[{nxt_cnt[1:0], 3'b000} +: 8];
        nxt_lane  = d_alane;
        nxt_drive = 1'b1;
      end
      PH_DUMMY: begin
        nxt_lane  = d_alane;
      end
      PH_DATA: begin
        nxt_byte  = (d_dir == DIR_OUT) ? wr_data : 8'h00;
        nxt_lane  = d_dlane;
        nxt_drive = (d_dir == DIR_OUT);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (lane_r)
      LANE_X1: sh_next = {sh[6:0], 1'b0};
      LANE_X2: sh_next = {sh[5:0], 2'b00};
      default: sh_next = {sh[3:0], 4'b0000};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= PH_CMD;
      cnt        <= '0;
      beats      <= '0;
      sh         <= '0;
      lane_r     <= LANE_X1;
      oe_r       <= '0;
      cs_n_r     <= 1'b1;
      sclk_r     <= 1'b0;
      done_r     <= 1'b0;
      rd_valid_r <= 1'b0;
      wr_take_r  <= 1'b0;
      rd_data_r  <= '0;
      d_acnt     <= '0;
      d_addr     <= '0;
      d_dummy    <= '0;
      d_dir      <= DIR_NONE;
      d_len      <= '0;
      d_alane    <= LANE_X1;
      d_dlane    <= LANE_X1;
    end else begin
      done_r     <= 1'b0;
      rd_valid_r <= 1'b0;
      wr_take_r  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            d_acnt  <= addr_count;
            d_addr  <= addr_value;
            d_dummy <= dummy_count;
            d_dir   <= data_dir;
            d_len   <= data_count;
            d_alane <= addr_lanes;
            d_dlane <= data_lanes;
            cs_n_r  <= 1'b0;
            phase   <= PH_CMD;
            cnt     <= '0;
            sh      <= op_code;
            lane_r  <= LANE_X1;
            beats   <= beats_per_byte(LANE_X1);
            oe_r    <= lane_mask(LANE_X1);
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          sclk_r <= 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: begin
          sclk_r <= 1'b0;
          if (beats != 4'd1) begin
            beats <= beats - 4'd1;
            sh    <= sh_next;
            state <= ST_LOW;
          end else begin
            if ((phase == PH_DATA) && (d_dir == DIR_IN)) begin
              rd_valid_r <= 1'b1;
              rd_data_r  <= rd_byte;
            end
            if (nxt_valid) begin
              phase     <= nxt_phase;
              cnt       <= nxt_cnt;
              sh        <= nxt_byte;
              lane_r    <= nxt_lane;
              beats     <= beats_per_byte(nxt_lane);
              oe_r      <= nxt_drive ? lane_mask(nxt_lane) : 4'b0000;
              wr_take_r <= (nxt_phase == PH_DATA) && (d_dir == DIR_OUT);
              state     <= ST_LOW;
            end else begin
              oe_r  <= 4'b0000;
              state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          cs_n_r <= 1'b1;
          done_r <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_r;
  assign cs_n     = cs_n_r;
  assign sclk     = sclk_r;
  assign io_oe    = oe_r;
  assign rd_valid = rd_valid_r;
  assign rd_data  = rd_data_r;
  assign wr_take  = wr_take_r;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       rd_valid,
  input logic       wr_take
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (io_oe == 4'b0000 && !sclk)); // R1

  AST_CS_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_SCLK_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    sclk |=> !sclk); // R3

  AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n); // R3

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> ($past(start) && !$past(busy))); // R10

  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (io_oe == 4'b0000)); // R9

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_take |=> !wr_take); // R8

endmodule

bind sflash_seq sfs_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .io_oe   (io_oe),
  .rd_valid(rd_valid),
  .wr_take (wr_take)
);

// File: tb/sim_sflash_seq.sv
`timescale 1ns/1ps
module sim_sflash_seq;

  localparam int DUMMY_W = 3;
  localparam int LEN_W   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst, start;
  logic [7:0]         op_code;
  logic [1:0]         addr_count;
  logic [23:0]        addr_value;
  logic [DUMMY_W-1:0] dummy_count;
  logic [1:0]         data_dir;
  logic [LEN_W-1:0]   data_count;
  logic [1:0]         addr_lanes, data_lanes;
  logic [7:0]         wr_data;
  logic               wr_take, rd_valid, busy, done, cs_n, sclk;
  logic [7:0]         rd_data;
  logic [3:0]         io_out, io_oe, io_in;

  sflash_seq #(.ADDR_BYTES_MAX(3), .DUMMY_W(DUMMY_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code),
    .addr_count(addr_count), .addr_value(addr_value),
    .dummy_count(dummy_count), .data_dir(data_dir), .data_count(data_count),
    .addr_lanes(addr_lanes), .data_lanes(data_lanes), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  int checks = 0;
  int errors = 0;

  int q_out[$];
  int q_oe[$];
  int q_in[$];
  int q_rd[$];
  int q_wl[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind: 0 driven, 1 dummy, 2 read, 3 write
  task automatic add_byte(input int val, input int lc, input int kind);
    int ln, nb, ch;
    ln = (lc == 0) ? 1 : (lc == 1) ? 2 : 4;
    nb = 8 / ln;
    for (int k = 0; k < nb; k++) begin
      ch = (val >> (8 - ln * (k + 1))) & ((1 << ln) - 1);
      q_out.push_back((kind == 0 || kind == 3) ? ch : 0);
      q_oe.push_back((kind == 0 || kind == 3) ? ((1 << ln) - 1) : 0);
      q_in.push_back((kind == 2) ? ((ln == 1) ? (ch << 1) : ch) : 0);
      q_rd.push_back((kind == 2 && k == nb - 1) ? val : -1);
      q_wl.push_back((kind == 3 && k == 0) ? 1 : 0);
    end
  endtask

  task automatic run_txn(input string tag, input int opc, input int nab,
                         input int addr, input int ndum, input int dir,
                         input int len, input int alc, input int dlc,
                         input bit poke);
    int dbytes[$];
    int wi, n, b, eo, ev, er, ew;
    q_out.delete(); q_oe.delete(); q_in.delete(); q_rd.delete(); q_wl.delete();
    for (int j = 0; j < len; j++) dbytes.push_back((opc * 7 + j * 37 + 11) & 255);
    add_byte(opc, 0, 0);
    for (int i = nab - 1; i >= 0; i--) add_byte((addr >> (8 * i)) & 255, alc, 0);
    for (int i = 0; i < ndum; i++) add_byte(0, alc, 1);
    if (dir == 1) for (int j = 0; j < len; j++) add_byte(dbytes[j], dlc, 2);
    if (dir == 2) for (int j = 0; j < len; j++) add_byte(dbytes[j], dlc, 3);
    n = q_out.size();

    @(negedge clk);
    op_code     = 8'(opc);
    addr_count  = 2'(nab);
    addr_value  = 24'(addr);
    dummy_count = DUMMY_W'(ndum);
    data_dir    = 2'(dir);
    data_count  = LEN_W'(len);
    addr_lanes  = 2'(alc);
    data_lanes  = 2'(dlc);
    wi          = 0;
    wr_data     = (dir == 2 && len > 0) ? 8'(dbytes[0]) : 8'h00;
    start       = 1'b1;

    for (int c = 0; c <= 2 * n + 1; c++) begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (c <= 2 * n) begin
        chk({tag, " R2 cs_n low"}, cs_n, 0);
        chk({tag, " R2 busy"}, busy, 1);
        chk({tag, " R2 done early"}, done, 0);
        chk({tag, " R3 sclk"}, sclk, c % 2);
        b  = (c == 0) ? 0 : ((c % 2) ? (c - 1) / 2 : c / 2);
        eo = (b < n) ? q_oe[b] : 0;
        ev = (b < n) ? q_out[b] : 0;
        chk({tag, " R7 io_oe"}, io_oe, eo);
        chk({tag, " R4 io_out"}, io_out & eo, ev & eo);
      end else begin
        chk({tag, " R2 cs_n high"}, cs_n, 1);
        chk({tag, " R2 done"}, done, 1);
        chk({tag, " R2 busy end"}, busy, 0);
        chk({tag, " R1 io_oe idle"}, io_oe, 0);
      end
      er = (c >= 2 && (c % 2) == 0 && (c / 2 - 1) < n) ? q_rd[c / 2 - 1] : -1;
      chk({tag, " R9 rd_valid"}, rd_valid, (er >= 0) ? 1 : 0);
      if (er >= 0) chk({tag, " R9 rd_data"}, rd_data, er);
      ew = ((c % 2) == 0 && (c / 2) < n) ? q_wl[c / 2] : 0;
      chk({tag, " R8 wr_take"}, wr_take, ew);
      if ((c % 2) == 0 && (c / 2) < n) io_in = 4'(q_in[c / 2]);
      if (wr_take) begin
        wi++;
        wr_data = (wi < dbytes.size()) ? 8'(dbytes[wi]) : 8'h00;
      end
      if (poke && c == 5) begin
        start      = 1'b1;
        op_code    = 8'hFF;
        addr_count = 2'd0;
        data_dir   = 2'd0;
      end
      if (poke && c == 6) start = 1'b0;
    end
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, done, 0);
    chk({tag, " R1 cs_n idle"}, cs_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; op_code = '0; addr_count = '0; addr_value = '0;
    dummy_count = '0; data_dir = '0; data_count = '0; addr_lanes = '0;
    data_lanes = '0; wr_data = '0; io_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset sclk", sclk, 0);
    chk("R1 reset io_oe", io_oe, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset rd_valid", rd_valid, 0);
    chk("R1 reset wr_take", wr_take, 0);

    run_txn("R11 opcode-only",    8'h06, 0, 0,        0, 0, 0, 0, 0, 1'b0);
    run_txn("R11 empty-data",     8'h9F, 0, 0,        0, 1, 0, 0, 0, 1'b0);
    run_txn("R5 R9 feature-read", 8'h0F, 1, 'hC0,     0, 1, 1, 0, 0, 1'b0);
    run_txn("R5 three-byte-addr", 8'hD8, 3, 'h12A5C3, 0, 0, 0, 0, 0, 1'b0);
    run_txn("R6 dual-data-read",  8'h3B, 2, 'h0123,   1, 1, 3, 0, 1, 1'b0);
    run_txn("R7 quad-io-read",    8'hEB, 2, 'h0456,   2, 1, 4, 2, 2, 1'b0);
    run_txn("R7 dual-io-read",    8'hBB, 2, 'h0789,   1, 1, 2, 1, 1, 1'b0);
    run_txn("R8 quad-load",       8'h32, 2, 'h0010,   0, 2, 3, 0, 2, 1'b0);
    run_txn("R10 busy-start",     8'h02, 2, 'h0200,   0, 2, 2, 0, 0, 1'b1);
    run_txn("R6 dual-dummy-write",8'h84, 2, 'h0033,   1, 2, 2, 1, 1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule